// File: doc/BRIEF.md
# Flash Program/Erase Protection Controller

This block guards the program and erase control lines of an on-chip flash array. A CPU writes a small register set over a simple synchronous bus. Program or erase mode reaches the array only when three conditions hold: software has unlocked the array, the request is well formed, and the error latch is clear. An erase also needs at least one block selected in the block-select register.

The guard also watches for conditions that make an operation in progress unsafe and aborts it. Some of these return the whole register set to its initial state: an asynchronous reset, or a request to enter a low-power mode (sub-clock active, sub-clock sleep or standby). Others abort the operation and set a sticky error latch: a read that touches the flash address range (including vector reads and instruction fetches), the start of a non-reset exception, or execution of a sleep instruction. In every abort case the program/erase drive is cleared on the same clock edge that samples the condition.

Register map:

| Address | Contents |
|---|---|
| 0 | Control: bit 0 unlock, bit 1 program, bit 2 erase |
| 1 | Status: read-only error flag in the top bit |
| 2 | Block select: one bit per block |
| 3 | Reads as zero |

Top module: `flash_pe_guard`

## Requirements
- R1: After reset, every register reads zero, and program_active, erase_active, erase_blocks and error_flag are low.
- R2: The map is as follows. Address 0 is control: bit 0 unlock, bit 1 program, bit 2 erase. Address 1 is status, with the error flag in bit 7; bus writes to it have no effect. Address 2 is block select. Address 3 and all unused bits read 0. Read data is combinational from the address.
- R3: A control write with unlock=1, program=1 and erase=0 sets program_active at the next edge. This holds only if the stored unlock bit was already 1 and the error flag is 0.
- R4: While the stored unlock bit is 0, a control write never sets the program or erase bit. A write that clears unlock also drops both modes.
- R5: Erase entry follows the rule in R3 and also needs a non-zero block select. With block select 0x00, the erase bit stays 0 and the error flag is not set. While erasing, erase_blocks equals block select; otherwise it is zero.
- R6: A control write with program and erase both 1 enters neither mode.
- R7: A flash read while a mode is active sets the error flag and clears both modes at the next edge. Any bus write in that cycle is discarded.
- R8: The start of a non-reset exception while a mode is active behaves as in R7.
- R9: Execution of a sleep instruction while a mode is active behaves as in R7.
- R10: Flash reads, exceptions and sleep events while no mode is active have no effect.
- R11: The error flag stays set until reset or low-power entry. While it is set, the program and erase bits of control writes are ignored, but the unlock bit is still written.
- R12: low_power_req returns every register to zero at the next edge. It takes priority over writes and error events.
- R13: Asserting rst_n low clears all outputs at once, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | DATA_W | Read data |
| flash_read | input | 1 | A read in the flash range is being made (data, vector or fetch) |
| exception_start | input | 1 | Non-reset exception handling begins |
| sleep_exec | input | 1 | Sleep instruction executed |
| low_power_req | input | 1 | Transition into a low-power mode |
| program_active | output | 1 | Program drive to the array |
| erase_active | output | 1 | Erase drive to the array |
| erase_blocks | output | DATA_W | Blocks being erased |
| error_flag | output | 1 | Error-protection state |

## Verification
The bench attacks ordering and priority corners. One case sets unlock and program in the same write from a locked state; a design that checked the written unlock bit instead of the stored one would start programming. Another case places an abort event in the same cycle as a control write; a design that let the write win would leave the array driven after a fault. The bench also checks that an erase request with no block selected neither starts nor faults. It checks that the error latch survives later writes but not low-power entry, and that idle-time faults are harmless. A design that flagged every flash read as a fault would trip the error latch during normal execution.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_BLK  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  localparam int CTRL_UNLOCK = 0;
  localparam int CTRL_PROG   = 1;
  localparam int CTRL_ERASE  = 2;
  localparam int CTRL_BITS   = 3;

  typedef struct packed {
    logic ers;
    logic prg;
    logic swe;
  } ctrl_t;
endpackage

// File: rtl/fpg_rst_sync.sv
module fpg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/fpg_error_detect.sv
module fpg_error_detect (
  input  logic op_active,
  input  logic flash_read,
  input  logic exception_start,
  input  logic sleep_exec,
  output logic err_event
);
  logic fault_src;

  always_comb begin
    fault_src = flash_read | exception_start | sleep_exec;
    err_event = op_active & fault_src;
  end
endmodule

// File: rtl/fpg_ctrl_regs.sv
module fpg_ctrl_regs
  import fpg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_blk,
  input  logic [DATA_W-1:0] wdata,
  input  logic              err_event,
  input  logic              low_power_req,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] blk,
  output logic              err
);
  ctrl_t             ctrl_q, ctrl_n;
  logic [DATA_W-1:0] blk_q, blk_n;
  logic              err_q, err_n;
  logic              upd_en;
  logic              go_ok;

  always_comb begin
    ctrl_n = ctrl_q;
    blk_n  = blk_q;
    err_n  = err_q;
    go_ok  = 1'b0;
    upd_en = wr_ctrl | wr_blk | err_event | low_power_req;
    if (low_power_req) begin
      ctrl_n = '0;
      blk_n  = '0;
      err_n  = 1'b0;
    end else if (err_event) begin
      err_n      = 1'b1;
      ctrl_n.prg = 1'b0;
      ctrl_n.ers = 1'b0;
    end else begin
      if (wr_ctrl) begin
        go_ok = ctrl_q.swe & wdata[CTRL_UNLOCK] & ~err_q &
                ~(wdata[CTRL_PROG] & wdata[CTRL_ERASE]);
        ctrl_n.swe = wdata[CTRL_UNLOCK];
        ctrl_n.prg = go_ok & wdata[CTRL_PROG];
        ctrl_n.ers = go_ok & wdata[CTRL_ERASE] & (|blk_q);
      end
      if (wr_blk) blk_n = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      blk_q  <= '0;
      err_q  <= 1'b0;
    end else if (upd_en) begin
      ctrl_q <= ctrl_n;
      blk_q  <= blk_n;
      err_q  <= err_n;
    end
  end

  assign ctrl = ctrl_q;
  assign blk  = blk_q;
  assign err  = err_q;

  assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_q.prg && ctrl_q.ers));

  assert_unlock_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.swe |=> (!ctrl_q.prg && !ctrl_q.ers));

  assert_prog_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && ctrl_q.swe && !err_q && !err_event && !low_power_req &&
     wdata[CTRL_UNLOCK] && wdata[CTRL_PROG] && !wdata[CTRL_ERASE]) |=> ctrl_q.prg);

  assert_erase_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q.ers) |-> (blk_q != '0));

  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !low_power_req) |=> err_q);

  assert_lowpower_R12: assert property (@(posedge clk) disable iff (!rst_n)
    low_power_req |=> (ctrl_q == '0 && blk_q == '0 && !err_q));
endmodule

// File: rtl/flash_pe_guard.sv
module flash_pe_guard
  import fpg_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              flash_read,
  input  logic              exception_start,
  input  logic              sleep_exec,
  input  logic              low_power_req,
  output logic              program_active,
  output logic              erase_active,
  output logic [DATA_W-1:0] erase_blocks,
  output logic              error_flag
);
  localparam int PAD_W = DATA_W - CTRL_BITS;

  logic              srst_n;
  logic              wr_ctrl, wr_blk;
  logic              op_active;
  logic              err_event;
  ctrl_t             ctrl;
  logic [DATA_W-1:0] blk;
  logic              err;
  reg_sel_e          sel;

  fpg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  always_comb begin
    sel     = reg_sel_e'(bus_addr);
    wr_ctrl = bus_we && (sel == REG_CTRL);
    wr_blk  = bus_we && (sel == REG_BLK);
  end

  assign op_active = ctrl.prg | ctrl.ers;

  fpg_error_detect u_err_det (
    .op_active       (op_active),
    .flash_read      (flash_read),
    .exception_start (exception_start),
    .sleep_exec      (sleep_exec),
    .err_event       (err_event)
  );

  fpg_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
    .clk           (clk),
    .rst_n         (srst_n),
    .wr_ctrl       (wr_ctrl),
    .wr_blk        (wr_blk),
    .wdata         (bus_wdata),
    .err_event     (err_event),
    .low_power_req (low_power_req),
    .ctrl          (ctrl),
    .blk           (blk),
    .err           (err)
  );

  always_comb begin
    case (sel)
      REG_CTRL: bus_rdata = {{PAD_W{1'b0}}, ctrl.ers, ctrl.prg, ctrl.swe};
      REG_STAT: bus_rdata = {err, {(DATA_W-1){1'b0}}};
      REG_BLK:  bus_rdata = blk;
      default:  bus_rdata = '0;
    endcase
  end

  assign program_active = ctrl.prg;
  assign erase_active   = ctrl.ers;
  assign erase_blocks   = ctrl.ers ? blk : '0;
  assign error_flag     = err;

  assert_flash_read_abort_R7: assert property (@(posedge clk) disable iff (!srst_n)
    (op_active && flash_read && !low_power_req) |=>
      (error_flag && !program_active && !erase_active));

  assert_exception_abort_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (op_active && exception_start && !low_power_req) |=>
      (error_flag && !program_active && !erase_active));

  assert_sleep_abort_R9: assert property (@(posedge clk) disable iff (!srst_n)
    (op_active && sleep_exec && !low_power_req) |=>
      (error_flag && !program_active && !erase_active));

  assert_idle_fault_R10: assert property (@(posedge clk) disable iff (!srst_n)
    (!op_active && !error_flag && !low_power_req) |=> !error_flag);

  assert_erase_out_R5: assert property (@(posedge clk) disable iff (!srst_n)
    !erase_active |-> (erase_blocks == '0));
endmodule

// File: tb/flash_pe_guard_bench.sv
module flash_pe_guard_bench;
  localparam int DW = 8;

  logic          clk;
  logic          rst_n;
  logic [1:0]    bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_we;
  logic [DW-1:0] bus_rdata;
  logic          flash_read, exception_start, sleep_exec, low_power_req;
  logic          program_active, erase_active, error_flag;
  logic [DW-1:0] erase_blocks;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  bit       m_swe, m_prg, m_ers, m_err;
  bit [7:0] m_blk;

  flash_pe_guard #(.DATA_W(DW)) u_flash_pe_guard (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .flash_read(flash_read),
    .exception_start(exception_start), .sleep_exec(sleep_exec),
    .low_power_req(low_power_req), .program_active(program_active),
    .erase_active(erase_active), .erase_blocks(erase_blocks),
    .error_flag(error_flag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit [7:0] m_read(bit [1:0] a);
    case (a)
      2'd0: return {5'b0, m_ers, m_prg, m_swe};
      2'd1: return {m_err, 7'b0};
      2'd2: return m_blk;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_clear();
    m_swe = 0; m_prg = 0; m_ers = 0; m_err = 0; m_blk = 8'h00;
  endtask

  task automatic check_outs(string tag);
    chk(tag, "program_active", int'(program_active), int'(m_prg));
    chk(tag, "erase_active",   int'(erase_active),   int'(m_ers));
    chk(tag, "erase_blocks",   int'(erase_blocks),   int'(m_ers ? m_blk : 8'h00));
    chk(tag, "error_flag",     int'(error_flag),     int'(m_err));
  endtask

  task automatic step(string tag, bit we, bit [1:0] a, bit [7:0] d,
                      bit fr = 0, bit exc = 0, bit slp = 0, bit lp = 0);
    bit n_swe, n_prg, n_ers, n_err, ok;
    bit [7:0] n_blk;
    bus_we = we; bus_addr = a; bus_wdata = d;
    flash_read = fr; exception_start = exc; sleep_exec = slp; low_power_req = lp;
    #1;
    chk(tag, "bus_rdata", int'(bus_rdata), int'(m_read(a)));
    n_swe = m_swe; n_prg = m_prg; n_ers = m_ers; n_err = m_err; n_blk = m_blk;
    if (lp) begin
      n_swe = 0; n_prg = 0; n_ers = 0; n_err = 0; n_blk = 0;
    end else if ((m_prg || m_ers) && (fr || exc || slp)) begin
      n_err = 1; n_prg = 0; n_ers = 0;
    end else if (we && a == 2'd0) begin
      ok    = m_swe && d[0] && !m_err && !(d[1] && d[2]);
      n_swe = d[0];
      n_prg = ok && d[1];
      n_ers = ok && d[2] && (m_blk != 0);
    end else if (we && a == 2'd2) begin
      n_blk = d;
    end
    @(posedge clk);
    m_swe = n_swe; m_prg = n_prg; m_ers = n_ers; m_err = n_err; m_blk = n_blk;
    #1;
    check_outs(tag);
  endtask

  task automatic do_reset(string tag);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    model_clear();
    check_outs(tag);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    for (int i = 0; i < 3; i++) step(tag, 0, 2'd3, 8'h00);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    bus_we = 0; bus_addr = 0; bus_wdata = 0;
    flash_read = 0; exception_start = 0; sleep_exec = 0; low_power_req = 0;
    model_clear();
    do_reset("R1");
    for (int a = 0; a < 4; a++) step("R1", 0, 2'(a), 8'h00);

    // R4: locked, unlock+program in one write must not start
    step("R4", 1, 2'd0, 8'h03);
    step("R4", 1, 2'd0, 8'h07);
    step("R3", 1, 2'd0, 8'h01);
    step("R3", 1, 2'd0, 8'h03);
    step("R2", 0, 2'd0, 8'h00);
    // R2: status write ignored
    step("R2", 1, 2'd1, 8'hFF);
    step("R2", 0, 2'd1, 8'h00);
    // R5: erase with no blocks
    step("R5", 1, 2'd0, 8'h05);
    step("R5", 0, 2'd1, 8'h00);
    step("R5", 1, 2'd2, 8'h5A);
    step("R2", 0, 2'd2, 8'h00);
    step("R5", 1, 2'd0, 8'h05);
    step("R5", 0, 2'd0, 8'h00);
    // R6: both bits
    step("R6", 1, 2'd0, 8'h07);
    step("R6", 0, 2'd0, 8'h00);
    // R4: clearing unlock drops the mode
    step("R4", 1, 2'd0, 8'h01);
    step("R4", 1, 2'd0, 8'h03);
    step("R4", 1, 2'd0, 8'h02);
    // R10: idle faults
    step("R10", 0, 2'd3, 8'h00, 1, 0, 0);
    step("R10", 0, 2'd3, 8'h00, 0, 1, 0);
    step("R10", 0, 2'd3, 8'h00, 0, 0, 1);
    step("R10", 0, 2'd1, 8'h00);
    // R7: flash read during program, with a concurrent write discarded
    step("R7", 1, 2'd0, 8'h01);
    step("R7", 1, 2'd0, 8'h03);
    step("R7", 1, 2'd2, 8'hC3, 1, 0, 0);
    step("R7", 0, 2'd2, 8'h00);
    step("R11", 0, 2'd1, 8'h00);
    step("R11", 1, 2'd0, 8'h03);
    step("R11", 1, 2'd0, 8'h00);
    step("R11", 0, 2'd0, 8'h00);
    // R12: low power with write pending
    step("R12", 1, 2'd0, 8'h01);
    step("R12", 1, 2'd2, 8'hFF, 0, 0, 0, 1);
    for (int a = 0; a < 4; a++) step("R12", 0, 2'(a), 8'h00);
    // R8: exception during erase
    step("R8", 1, 2'd2, 8'h81);
    step("R8", 1, 2'd0, 8'h01);
    step("R8", 1, 2'd0, 8'h05);
    step("R8", 0, 2'd3, 8'h00, 0, 1, 0);
    step("R8", 0, 2'd1, 8'h00);
    do_reset("R1");
    // R9: sleep during program
    step("R9", 1, 2'd0, 8'h01);
    step("R9", 1, 2'd0, 8'h03);
    step("R9", 0, 2'd3, 8'h00, 0, 0, 1);
    step("R9", 0, 2'd1, 8'h00);
    // R13: asynchronous reset while erasing
    step("R13", 1, 2'd2, 8'h0F);
    step("R13", 1, 2'd0, 8'h05);
    step("R13", 0, 2'd0, 8'h00);
    do_reset("R13");
    step("R13", 0, 2'd2, 8'h00);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule